// File: doc/BRIEF.md
# Multi-function pin controller

This block turns three configurable control pins of a power-management device into internal control signals. One pin selects a voltage: either a dynamic select for an SD-card LDO or a power-up strap for the DDR buck rail. A second pin can act as a buck mode select or as an edge-triggered reset input. A third pin can act as a buck mode select or as a level-sensitive standby input. Each pin is synchronized and deglitched before it is used.

Configuration bits give each pin its role. A single mode-override bit can force PWM regardless of the pins. The warm/cold response, the set of rails that standby disables and the SD select polarity are also configuration bits. The rail sequencer is replaced by two request/acknowledge pairs. The DDR strap is read at power-up by driving a weak pull-up and then a weak pull-down, which separates a pulled-up, a pulled-down and a floating pin.

Top module: `mfp_ctrl`

## Requirements
- R1: When both the reset pin and the standby pin are set to the mode role, only the reset pin controls PWM forcing. The standby pin then affects neither `pwm_force_o` nor `stby_req_o`.
- R2: Each pin is filtered. A level held for fewer than DEGLITCH clocks never reaches the outputs. A level held for DEGLITCH+3 clocks always does.
- R3: `pwm_force_o` is 1 when `mode_i2c_i` is 1, or when the selected mode pin is low after filtering. Otherwise it is 0 (automatic PFM).
- R4: With the reset pin in the reset role and `cfg_cold_i`=0, a filtered falling edge gives exactly one single-cycle `warm_rst_o` pulse. A rising edge gives nothing.
- R5: With `cfg_cold_i`=1, a falling edge raises `seq_down_req_o` until `seq_down_ack_i`, then `seq_up_req_o` until `seq_up_ack_i`. Edges that arrive during this sequence are ignored. The two requests are never high together, and no warm pulse occurs.
- R6: With the standby pin in the standby role, a low filtered level sets `stby_req_o`=1 and `stby_rails_o`=`cfg_stby_mask_i`. Otherwise both are 0. This does not depend on the mode function of the reset pin.
- R7: With `cfg_vsel_ddr_i`=0, `ldo_code_o` is V18_CODE when the filtered select pin equals `cfg_vsel_pol_i`, and `ldo_reg_code_i` otherwise. With `cfg_vsel_ddr_i`=1, `ldo_code_o` is always `ldo_reg_code_i`.
- R8: The strap is read once after reset and latched until the next reset. High in both phases maps to V135_CODE, low in both phases maps to V120_CODE, and any other result (floating) maps to `buck3_reg_code_i`. `buck3_code_o` shows the decoded value only when `cfg_vsel_ddr_i`=1 and detection is complete. Otherwise it is `buck3_reg_code_i`.
- R9: After reset, `strap_pu_o` is high for SETTLE clocks and then `strap_pd_o` is high for SETTLE clocks. The two are never high together, and both stay 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset (power cycle) |
| pin_vsel_i | input | 1 | Voltage-select pin level |
| pin_rst_i | input | 1 | Reset/mode pin level |
| pin_stby_i | input | 1 | Standby/mode pin level |
| cfg_vsel_ddr_i | input | 1 | 1: select pin is DDR strap; 0: SD select |
| cfg_vsel_pol_i | input | 1 | Pin level that selects V18_CODE |
| cfg_rst_is_mode_i | input | 1 | 1: reset pin acts as mode; 0: reset |
| cfg_stby_is_mode_i | input | 1 | 1: standby pin acts as mode; 0: standby |
| cfg_cold_i | input | 1 | 1: cold reset response; 0: warm |
| cfg_stby_mask_i | input | NUM_RAILS | Rails disabled in standby |
| mode_i2c_i | input | 1 | Register override forcing PWM |
| ldo_reg_code_i | input | CODE_W | Programmed LDO code |
| buck3_reg_code_i | input | CODE_W | Programmed buck3 code |
| seq_down_ack_i | input | 1 | Sequencer finished power-down |
| seq_up_ack_i | input | 1 | Sequencer finished power-up |
| pwm_force_o | output | 1 | Force bucks into PWM |
| stby_req_o | output | 1 | Standby request |
| stby_rails_o | output | NUM_RAILS | Rails to disable |
| warm_rst_o | output | 1 | Warm reset pulse |
| seq_down_req_o | output | 1 | Cold reset: sequence rails down |
| seq_up_req_o | output | 1 | Cold reset: sequence rails up |
| ldo_code_o | output | CODE_W | Selected LDO voltage code |
| buck3_code_o | output | CODE_W | Selected buck3 voltage code |
| strap_pu_o | output | 1 | Weak pull-up enable on select pin |
| strap_pd_o | output | 1 | Weak pull-down enable on select pin |

## Verification
Random settings of the role bits, pin levels, override bit, polarity and mask are applied. Each setting is held until the filters settle, which separates the mode priority cases, the combined standby-plus-mode case and both select polarities. Directed pulses just shorter than the deglitch window, and levels just longer than it, show whether the filter is too permissive or too strict. Falling and rising edges in warm mode, and repeated edges during a cold sequence, separate edge detection from level detection. Three power-ups with the strap tied high, tied low and left floating check all three decoded codes.

// File: rtl/mfp_pkg.sv
package mfp_pkg;
  localparam int NUM_PINS = 3;
  localparam int PIN_VSEL = 0;
  localparam int PIN_RST  = 1;
  localparam int PIN_STBY = 2;

  typedef enum logic [1:0] {RS_IDLE, RS_DOWN, RS_UP} rst_st_e;
  typedef enum logic [1:0] {ST_PU, ST_PD, ST_DONE} strap_st_e;
endpackage

// File: rtl/mfp_filter.sv
module mfp_filter #(
  parameter int DEGLITCH = 16,
  parameter bit RST_VAL  = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic filt_o
);
  localparam int CW = $clog2(DEGLITCH + 1);
  localparam logic [CW-1:0] LAST = CW'(DEGLITCH - 1);

  logic s1_q, s2_q, filt_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= RST_VAL;
      s2_q   <= RST_VAL;
      filt_q <= RST_VAL;
      cnt_q  <= '0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
      if (s2_q == filt_q) begin
        cnt_q <= '0;
      end else if (cnt_q == LAST) begin
        filt_q <= s2_q;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign filt_o = filt_q;

  // filtered level only ever moves toward the synchronized input
  assert_filt_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(filt_q) |-> filt_q == $past(s2_q));
endmodule

// File: rtl/mfp_rst_seq.sv
module mfp_rst_seq
  import mfp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic filt_i,
  input  logic cold_i,
  input  logic down_ack_i,
  input  logic up_ack_i,
  output logic warm_o,
  output logic down_req_o,
  output logic up_req_o
);
  rst_st_e state_q;
  logic    prev_q, warm_q, fall;

  assign fall = en_i & prev_q & ~filt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RS_IDLE;
      prev_q  <= 1'b1;
      warm_q  <= 1'b0;
    end else begin
      prev_q <= filt_i;
      warm_q <= 1'b0;
      unique case (state_q)
        RS_IDLE: if (fall) begin
          if (cold_i) state_q <= RS_DOWN;
          else        warm_q  <= 1'b1;
        end
        RS_DOWN: if (down_ack_i) state_q <= RS_UP;
        RS_UP:   if (up_ack_i)   state_q <= RS_IDLE;
        default: state_q <= RS_IDLE;
      endcase
    end
  end

  assign warm_o     = warm_q;
  assign down_req_o = (state_q == RS_DOWN);
  assign up_req_o   = (state_q == RS_UP);

  assert_warm_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm_q |=> !warm_q);
  // filter cannot release within one cycle, so pin is still low at the pulse
  assert_warm_pin_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm_q |-> !filt_i);
  assert_req_exclusive_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({warm_q, down_req_o, up_req_o}));
  assert_down_then_up_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    down_req_o && down_ack_i |=> up_req_o);
endmodule

// File: rtl/mfp_strap.sv
module mfp_strap
  import mfp_pkg::*;
#(
  parameter int SETTLE = 24,
  parameter int CODE_W = 8,
  parameter logic [CODE_W-1:0] V135_CODE = 8'd30,
  parameter logic [CODE_W-1:0] V120_CODE = 8'd24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pin_i,
  input  logic [CODE_W-1:0] reg_code_i,
  output logic              pu_o,
  output logic              pd_o,
  output logic              done_o,
  output logic [CODE_W-1:0] code_o
);
  localparam int CW = $clog2(SETTLE + 1);
  localparam logic [CW-1:0] LAST = CW'(SETTLE - 1);

  strap_st_e     state_q;
  logic [CW-1:0] cnt_q;
  logic          up_q, dn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_PU;
      cnt_q   <= '0;
      up_q    <= 1'b0;
      dn_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_PU: if (cnt_q == LAST) begin
          up_q    <= pin_i;
          cnt_q   <= '0;
          state_q <= ST_PD;
        end else cnt_q <= cnt_q + 1'b1;
        ST_PD: if (cnt_q == LAST) begin
          dn_q    <= pin_i;
          cnt_q   <= '0;
          state_q <= ST_DONE;
        end else cnt_q <= cnt_q + 1'b1;
        default: state_q <= ST_DONE;
      endcase
    end
  end

  assign pu_o   = (state_q == ST_PU);
  assign pd_o   = (state_q == ST_PD);
  assign done_o = (state_q == ST_DONE);

  always_comb begin
    if (!done_o)           code_o = reg_code_i;
    else if (up_q && dn_q)   code_o = V135_CODE;
    else if (!up_q && !dn_q) code_o = V120_CODE;
    else                     code_o = reg_code_i;
  end

  assert_strap_latched_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && $past(done_o) |-> $stable({up_q, dn_q}));
  assert_pulls_exclusive_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pu_o && pd_o));
  assert_pulls_off_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o && !pu_o && !pd_o);
endmodule

// File: rtl/mfp_ctrl.sv
module mfp_ctrl
  import mfp_pkg::*;
#(
  parameter int DEGLITCH  = 16,
  parameter int SETTLE    = 24,
  parameter int NUM_RAILS = 7,
  parameter int CODE_W    = 8,
  parameter logic [CODE_W-1:0] V18_CODE  = 8'd48,
  parameter logic [CODE_W-1:0] V135_CODE = 8'd30,
  parameter logic [CODE_W-1:0] V120_CODE = 8'd24
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 pin_vsel_i,
  input  logic                 pin_rst_i,
  input  logic                 pin_stby_i,
  input  logic                 cfg_vsel_ddr_i,
  input  logic                 cfg_vsel_pol_i,
  input  logic                 cfg_rst_is_mode_i,
  input  logic                 cfg_stby_is_mode_i,
  input  logic                 cfg_cold_i,
  input  logic [NUM_RAILS-1:0] cfg_stby_mask_i,
  input  logic                 mode_i2c_i,
  input  logic [CODE_W-1:0]    ldo_reg_code_i,
  input  logic [CODE_W-1:0]    buck3_reg_code_i,
  input  logic                 seq_down_ack_i,
  input  logic                 seq_up_ack_i,
  output logic                 pwm_force_o,
  output logic                 stby_req_o,
  output logic [NUM_RAILS-1:0] stby_rails_o,
  output logic                 warm_rst_o,
  output logic                 seq_down_req_o,
  output logic                 seq_up_req_o,
  output logic [CODE_W-1:0]    ldo_code_o,
  output logic [CODE_W-1:0]    buck3_code_o,
  output logic                 strap_pu_o,
  output logic                 strap_pd_o
);
  // strap phase must outlast synchronizer plus filter
  localparam int MIN_SETTLE = DEGLITCH + 3;

  logic [NUM_PINS-1:0] pins, filt;
  logic                mode_pin_low, stby_role, strap_done;
  logic [CODE_W-1:0]   strap_code;

  assign pins = {pin_stby_i, pin_rst_i, pin_vsel_i};

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    mfp_filter #(.DEGLITCH(DEGLITCH), .RST_VAL(1'b1)) u_filt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (pins[g]),
      .filt_o (filt[g])
    );
  end

  // reset pin wins the mode role when both claim it
  always_comb begin
    if (cfg_rst_is_mode_i)       mode_pin_low = ~filt[PIN_RST];
    else if (cfg_stby_is_mode_i) mode_pin_low = ~filt[PIN_STBY];
    else                         mode_pin_low = 1'b0;
  end

  assign stby_role    = ~cfg_stby_is_mode_i;
  assign pwm_force_o  = mode_i2c_i | mode_pin_low;
  assign stby_req_o   = stby_role & ~filt[PIN_STBY];
  assign stby_rails_o = stby_req_o ? cfg_stby_mask_i : '0;

  mfp_rst_seq u_rst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (~cfg_rst_is_mode_i),
    .filt_i     (filt[PIN_RST]),
    .cold_i     (cfg_cold_i),
    .down_ack_i (seq_down_ack_i),
    .up_ack_i   (seq_up_ack_i),
    .warm_o     (warm_rst_o),
    .down_req_o (seq_down_req_o),
    .up_req_o   (seq_up_req_o)
  );

  mfp_strap #(
    .SETTLE    (SETTLE < MIN_SETTLE ? MIN_SETTLE : SETTLE),
    .CODE_W    (CODE_W),
    .V135_CODE (V135_CODE),
    .V120_CODE (V120_CODE)
  ) u_strap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_i      (filt[PIN_VSEL]),
    .reg_code_i (buck3_reg_code_i),
    .pu_o       (strap_pu_o),
    .pd_o       (strap_pd_o),
    .done_o     (strap_done),
    .code_o     (strap_code)
  );

  assign ldo_code_o = (!cfg_vsel_ddr_i && (filt[PIN_VSEL] == cfg_vsel_pol_i))
                      ? V18_CODE : ldo_reg_code_i;
  assign buck3_code_o = (cfg_vsel_ddr_i && strap_done) ? strap_code : buck3_reg_code_i;

  assert_i2c_forces_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i2c_i |-> pwm_force_o);
  assert_stby_pin_ignored_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rst_is_mode_i && cfg_stby_is_mode_i && !mode_i2c_i && filt[PIN_RST]
    |-> !pwm_force_o && !stby_req_o);
  assert_stby_mask_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stby_req_o |-> stby_rails_o == '0);
  assert_ddr_ldo_reg_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_vsel_ddr_i |-> ldo_code_o == ldo_reg_code_i);
endmodule

// File: tb/tb_mfp_ctrl.sv
module tb_mfp_ctrl;
  localparam int DG = 16;
  localparam int ST = 24;
  localparam int NR = 7;
  localparam logic [7:0] V18 = 8'd48, V135 = 8'd30, V120 = 8'd24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pin_rst = 1'b1, pin_stby = 1'b1, sd_lvl = 1'b1;
  logic pin_vsel;
  logic c_ddr = 0, c_pol = 0, c_amode = 1, c_bmode = 0, c_cold = 0, i2c = 0;
  logic [NR-1:0] mask = '0;
  logic [7:0] ldo_reg = 8'h40, b3_reg = 8'h77;
  logic dn_ack = 0, up_ack = 0;
  logic pwm, stby, warm, sdn, sup, pu, pd;
  logic [NR-1:0] rails;
  logic [7:0] ldo, b3;
  int kind = 2;  // 0 tied high, 1 tied low, 2 floating
  int tests = 0, fails = 0, warm_cnt = 0, pwm_hi = 0;

  always #2 clk = ~clk;

  assign pin_vsel = (kind == 0) ? 1'b1 : (kind == 1) ? 1'b0 :
                    pu ? 1'b1 : pd ? 1'b0 : sd_lvl;

  mfp_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .pin_vsel_i(pin_vsel), .pin_rst_i(pin_rst),
    .pin_stby_i(pin_stby), .cfg_vsel_ddr_i(c_ddr), .cfg_vsel_pol_i(c_pol),
    .cfg_rst_is_mode_i(c_amode), .cfg_stby_is_mode_i(c_bmode), .cfg_cold_i(c_cold),
    .cfg_stby_mask_i(mask), .mode_i2c_i(i2c), .ldo_reg_code_i(ldo_reg),
    .buck3_reg_code_i(b3_reg), .seq_down_ack_i(dn_ack), .seq_up_ack_i(up_ack),
    .pwm_force_o(pwm), .stby_req_o(stby), .stby_rails_o(rails), .warm_rst_o(warm),
    .seq_down_req_o(sdn), .seq_up_req_o(sup), .ldo_code_o(ldo), .buck3_code_o(b3),
    .strap_pu_o(pu), .strap_pd_o(pd)
  );

  always @(negedge clk) begin
    if (warm) warm_cnt++;
    if (pwm) pwm_hi++;
  end

  function automatic bit exp_pwm(bit ov, bit am, bit bm, bit a, bit b);
    return ov | (am ? !a : (bm ? !b : 1'b0));
  endfunction
  function automatic bit exp_stby(bit bm, bit b);
    return !bm && !b;
  endfunction
  function automatic logic [7:0] exp_ldo(bit ddr, bit pol, bit lvl, logic [7:0] r);
    return (!ddr && lvl == pol) ? V18 : r;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic power_up(input int k);
    kind = k;
    rst_n = 1'b0;
    cyc(2);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    cyc(2);
    // reset state
    chk(!pwm && !stby && !warm && !sdn && !sup, "reset outputs R3", {pwm, stby, warm, sdn, sup}, 0);

    // R8/R9 strap decode for the three strap kinds
    c_ddr = 1;
    for (int k = 0; k < 3; k++) begin
      power_up(k);
      cyc(3);
      chk(pu && !pd, "R9 pull-up phase", {pu, pd}, 2);
      chk(b3 == b3_reg, "R8 code before done", b3, b3_reg);
      cyc(ST);
      chk(!pu && pd, "R9 pull-down phase", {pu, pd}, 1);
      cyc(ST + 10);
      chk(!pu && !pd, "R9 pulls off", {pu, pd}, 0);
      chk(b3 == ((k == 0) ? V135 : (k == 1) ? V120 : b3_reg), "R8 decoded code", b3,
          (k == 0) ? V135 : (k == 1) ? V120 : b3_reg);
      if (k == 1) begin
        c_ddr = 0;
        cyc(1);
        chk(b3 == b3_reg, "R8 sd role uses register", b3, b3_reg);
        c_ddr = 1;
      end
    end
    // floating strap now latched; register code follows the input
    b3_reg = 8'h5C;
    cyc(1);
    chk(b3 == 8'h5C, "R8 floating tracks register", b3, 8'h5C);

    // R2 deglitch on mode pin
    c_amode = 1; c_bmode = 0; i2c = 0; pin_rst = 1;
    cyc(DG + 4);
    pwm_hi = 0;
    pin_rst = 0; cyc(DG - 2); pin_rst = 1;
    cyc(DG + 6);
    chk(pwm_hi == 0, "R2 short pulse rejected", pwm_hi, 0);
    pin_rst = 0; cyc(DG + 3);
    chk(pwm == 1, "R2 long level accepted R3", pwm, 1);
    pin_rst = 1; cyc(DG + 4);
    chk(pwm == 0, "R3 released to auto", pwm, 0);

    // R1 both mode: standby pin ignored
    c_bmode = 1; pin_stby = 0;
    cyc(DG + 4);
    chk(!pwm && !stby, "R1 stby pin ignored", {pwm, stby}, 0);
    pin_stby = 1; cyc(DG + 4);

    // R4 warm reset
    c_amode = 0; c_bmode = 0; c_cold = 0;
    cyc(2);
    warm_cnt = 0;
    pin_rst = 0; cyc(DG + 10);
    chk(warm_cnt == 1, "R4 one warm pulse on fall", warm_cnt, 1);
    chk(!sdn && !sup && !pwm, "R4 no cold request", {sdn, sup, pwm}, 0);
    warm_cnt = 0;
    pin_rst = 1; cyc(DG + 10);
    chk(warm_cnt == 0, "R4 no pulse on rise", warm_cnt, 0);

    // R5 cold reset handshake
    c_cold = 1; warm_cnt = 0;
    pin_rst = 0; cyc(DG + 10);
    chk(sdn && !sup, "R5 down request", {sdn, sup}, 2);
    pin_rst = 1; cyc(DG + 6);
    pin_rst = 0; cyc(DG + 6);
    chk(sdn && !sup, "R5 edge ignored while down", {sdn, sup}, 2);
    dn_ack = 1; cyc(1); dn_ack = 0;
    chk(!sdn && sup, "R5 up request after ack", {sdn, sup}, 1);
    cyc(5);
    chk(!sdn && sup, "R5 up held", {sdn, sup}, 1);
    up_ack = 1; cyc(1); up_ack = 0;
    chk(!sdn && !sup, "R5 sequence done", {sdn, sup}, 0);
    chk(warm_cnt == 0, "R5 no warm during cold", warm_cnt, 0);
    pin_rst = 1; cyc(DG + 6);

    // R3 R6 R7 random sweep
    warm_cnt = 0;
    for (int i = 0; i < 80; i++) begin
      c_amode = 1'($urandom); c_bmode = 1'($urandom); i2c = 1'($urandom);
      c_ddr = 1'($urandom); c_pol = 1'($urandom); sd_lvl = 1'($urandom);
      mask = NR'($urandom); ldo_reg = 8'($urandom); b3_reg = 8'($urandom);
      pin_rst = c_amode ? 1'($urandom) : 1'b1;
      pin_stby = 1'($urandom);
      cyc(DG + 8);
      chk(pwm == exp_pwm(i2c, c_amode, c_bmode, pin_rst, pin_stby), "R3 R1 pwm", pwm,
          exp_pwm(i2c, c_amode, c_bmode, pin_rst, pin_stby));
      chk(stby == exp_stby(c_bmode, pin_stby), "R6 standby", stby, exp_stby(c_bmode, pin_stby));
      chk(rails == (exp_stby(c_bmode, pin_stby) ? mask : '0), "R6 rails", rails,
          exp_stby(c_bmode, pin_stby) ? mask : 0);
      chk(ldo == exp_ldo(c_ddr, c_pol, sd_lvl, ldo_reg), "R7 ldo code", ldo,
          exp_ldo(c_ddr, c_pol, sd_lvl, ldo_reg));
      chk(b3 == b3_reg, "R8 floating strap code", b3, b3_reg);
    end
    chk(warm_cnt == 0 && !sdn && !sup, "R4 R5 no reset in sweep", warm_cnt, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule